// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two N-bit two's-complement numbers over several clock cycles and returns their full 2N-bit signed product. A caller presents both operands with a one-cycle start strobe while the unit is idle. The unit then runs one recoding step per clock for N clocks. After that it raises a one-cycle completion pulse, and the product stays on the output until the next operation is accepted.

Each step looks at the lowest multiplier bit together with the bit that was shifted out on the previous step. The pair picks one of three actions on the upper half of a single accumulator register: add the multiplicand, subtract it, or leave the upper half alone. The whole register then shifts right by one bit arithmetically. The upper-half arithmetic is carried one bit wider than the operands, so the most negative multiplicand cannot overflow in the middle of a run. Because the shift is arithmetic, signed operands need no correction step.

Top module: `booth_mul_seq`

## Requirements
- R1: A synchronous active-high reset, even in the middle of an operation, returns the unit to idle: busy_o low, done_o low and product_o all zeros on the first clock after reset is released.
- R2: A start_i sampled high while idle sets busy_o on that clock edge. busy_o then stays high for exactly N clock cycles.
- R3: done_o goes high for exactly one cycle, in the cycle after the last busy cycle. busy_o is low whenever done_o is high.
- R4: When done_o is high, product_o holds the exact 2N-bit two's-complement product of the operands captured at start, for every combination of operand signs.
- R5: The recoding acts on the pair (current multiplier bit, previous bit). 01 adds the multiplicand to the upper half, 10 subtracts it, and 00 and 11 do neither. With N=4, 0010 × 1101 gives 8'hFA and 0010 × 0111 gives 8'h0E.
- R6: The most negative operand times itself gives +2^(2N-2): 8'h40 for N=4, and 64'h4000_0000_0000_0000 for N=32.
- R7: start_i and operand changes while busy_o is high have no effect. The busy length and the result of the running operation are unchanged.
- R8: While idle and not restarted, product_o keeps the last result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a multiply (accepted only while idle) |
| mcand_i | input | N | Signed multiplicand, captured on an accepted start |
| mplier_i | input | N | Signed multiplier, captured on an accepted start |
| busy_o | output | 1 | High while recoding steps are running |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2N | Signed product, held until the next accepted start |

## Verification
A corrupted step decision or a wrong shift-in bit changes the accumulator for good, so every such fault shows up as a wrong product_o at the next done pulse, at most N+1 cycles after start. A step counter that is off by one moves done_o and the busy window, and the busy-cycle count catches this on the very first operation. A lost sign extension in the upper-half arithmetic affects only operations that reach the most negative intermediate values, so the bench runs the extreme operand pairs and many random signed pairs.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic cur_bit,
    input  logic prev_bit,
    output op_e  op
);
    // R5: pair 01 -> add, 10 -> subtract, 00/11 -> no arithmetic
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  op_e          op,
    output logic [W:0]   sum
);
    localparam int XW = W + 1;

    logic [XW-1:0] acc_x;
    logic [XW-1:0] mc_x;

    // Sign-extend both sides by one bit so that the most negative
    // multiplicand cannot overflow the upper half mid-run.
    always_comb begin
        acc_x = {acc[W-1], acc};
        mc_x  = {mcand[W-1], mcand};
        unique case (op)
            OP_ADD:  sum = acc_x + mc_x;
            OP_SUB:  sum = acc_x - mc_x;
            default: sum = acc_x;
        endcase
    end
endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [2*N:0] p_cur,
    input  logic [N-1:0] mcand,
    output logic [2*N:0] p_next
);
    localparam int PW = 2 * N + 1;

    op_e          step_op;
    logic [N:0]   upper_sum;

    booth_recode u_recode (
        .cur_bit  (p_cur[1]),
        .prev_bit (p_cur[0]),
        .op       (step_op)
    );

    booth_addsub #(.W(N)) u_addsub (
        .acc   (p_cur[PW-1:N+1]),
        .mcand (mcand),
        .op    (step_op),
        .sum   (upper_sum)
    );

    // Arithmetic right shift of {widened upper, lower}: the widened
    // upper half supplies the new top bit, keeping the sign.
    always_comb begin
        p_next = {upper_sum, p_cur[N:1]};
    end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);
    localparam int PW = 2 * N + 1;
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        logic [PW-1:0] p;
        logic [N-1:0]  mcand;
        logic          done;
    } regs_t;

    regs_t         r_q;
    regs_t         r_d;
    logic [PW-1:0] p_step;

    booth_step #(.N(N)) u_step (
        .p_cur  (r_q.p),
        .mcand  (r_q.mcand),
        .p_next (p_step)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_RUN;
                    r_d.cnt   = '0;
                    r_d.p     = {{N{1'b0}}, mplier_i, 1'b0};
                    r_d.mcand = mcand_i;
                end
            end
            ST_RUN: begin
                r_d.p = p_step;
                if (r_q.cnt == LAST_STEP) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st == ST_RUN);
    assign done_o    = r_q.done;
    assign product_o = r_q.p[PW-1:1];

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && product_o == '0));

    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (r_q.cnt <= LAST_STEP));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R7
    mcand_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(r_q.mcand));

    // R8
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(product_o));
endmodule

// File: tb/test_booth_mul_seq.sv
module test_booth_mul_seq;
    localparam int N  = 32;
    localparam int N4 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic            start = 1'b0;
    logic [N-1:0]    a = '0;
    logic [N-1:0]    b = '0;
    logic            busy;
    logic            done;
    logic [2*N-1:0]  prod;

    logic            start4 = 1'b0;
    logic [N4-1:0]   a4 = '0;
    logic [N4-1:0]   b4 = '0;
    logic            busy4;
    logic            done4;
    logic [2*N4-1:0] prod4;

    booth_mul_seq #(.N(N)) i_booth_mul_seq (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(a), .mplier_i(b),
        .busy_o(busy), .done_o(done), .product_o(prod)
    );

    booth_mul_seq #(.N(N4)) i_booth_mul_seq_n4 (
        .clk(clk), .rst(rst), .start_i(start4), .mcand_i(a4), .mplier_i(b4),
        .busy_o(busy4), .done_o(done4), .product_o(prod4)
    );

    int checks = 0;
    int fails  = 0;
    logic signed [63:0] exp_q[$];
    logic signed [63:0] exp_v;
    logic [63:0] last_prod = '0;
    logic prev_done = 1'b0;

    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Driver: pushes the expected product, then counts busy cycles.
    task automatic issue(input logic [N-1:0] x, input logic [N-1:0] y, input bit poke);
        int nb;
        nb = 0;
        while (busy) @(negedge clk);
        start = 1'b1;
        a = x;
        b = y;
        exp_q.push_back(longint'($signed(x)) * longint'($signed(y)));
        @(negedge clk);
        while (busy) begin
            nb++;
            // R7: start strobes and operand changes while busy
            if (poke && (nb == 3 || nb == N)) begin
                start = 1'b1;
                a = ~x;
                b = y + 1'b1;
            end else begin
                start = 1'b0;
                a = $urandom;
                b = $urandom;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(nb == N, "R2 busy cycle count", 64'(nb), 64'(N));
    endtask

    task automatic run4(input logic [3:0] x, input logic [3:0] y,
                        input logic [7:0] exp, input string req);
        @(negedge clk);
        start4 = 1'b1;
        a4 = x;
        b4 = y;
        @(negedge clk);
        start4 = 1'b0;
        while (busy4) @(negedge clk);
        check(done4 && prod4 == exp, req, 64'(prod4), 64'(exp));
    endtask

    // Monitor: pops and compares on done, checks pulse width and hold.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done)
                check(!done, "R3 done longer than one cycle", 64'(done), 64'd0);
            if (done) begin
                check(!busy, "R3 busy high with done", 64'(busy), 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 done without pending operation", prod, 64'd0);
                end else begin
                    exp_v = exp_q.pop_front();
                    if (exp_v == 64'sh4000_0000_0000_0000)
                        check(prod == exp_v, "R6 most negative squared", prod, exp_v);
                    else
                        check(prod == exp_v, "R4 product", prod, exp_v);
                    last_prod = prod;
                end
            end else if (!busy) begin
                check(prod == last_prod, "R8 product held while idle", prod, last_prod);
            end
            prev_done = done;
        end else begin
            prev_done = 1'b0;
            last_prod = '0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && prod == '0, "R1 state after reset", prod, 64'd0);

        // R1: reset in the middle of an operation (not scoreboarded)
        @(negedge clk);
        start = 1'b1;
        a = 32'd12345;
        b = 32'd678;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && prod == '0, "R1 mid-run reset", {prod[62:0], busy}, 64'd0);

        // R5 / R6 / R4 at N=4
        run4(4'b0010, 4'b1101, 8'hFA, "R5 2 x -3");
        run4(4'b0010, 4'b0111, 8'h0E, "R5 2 x 7");
        run4(4'b1000, 4'b1000, 8'h40, "R6 -8 x -8 (N=4)");
        run4(4'b0111, 4'b1000, 8'hC8, "R4 7 x -8 (N=4)");

        // Directed corners at N=32
        issue(MINV, MINV, 1'b0);
        issue(MINV, MAXV, 1'b0);
        issue(MAXV, MAXV, 1'b0);
        issue('0, 32'hDEAD_BEEF, 1'b0);
        issue('1, '1, 1'b0);
        issue(32'd1, MINV, 1'b0);
        issue(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
        issue(MINV, 32'd3, 1'b1);

        for (int i = 0; i < 200; i++) begin
            issue($urandom, $urandom, (i % 7) == 0);
            if ((i % 10) == 0) repeat (4) @(negedge clk);
        end

        while (busy || done) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4 all operations completed", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule